// File: doc/BRIEF.md
# Up-counting event timer with PWM pin

A 32-bit up-counter advances once per tick. A tick is either every clock or one clock in every 2^(n+1), where n is a 3-bit field set by software. When the counter wraps from all ones to zero, that is an overflow. On overflow the counter either reloads from a load register and keeps running, or stops and holds zero. A compare register can raise a match event on the tick in which the counter holds its value.

Overflow events, and optionally match events, drive one event pin. The pin either gives a single-cycle pulse or changes level on each event, which produces PWM. When no events are selected, or the timer is stopped, the pin rests at a programmable idle level.

Three sticky status bits record match, overflow and capture events; the capture event is an external strobe from a separate capture block. Each bit is masked by its enable bit. A separate wake-up mask produces a one-cycle wake pulse. Software reaches the registers through a plain synchronous word port with a single-cycle write and a combinational read. There is no stream data path, so no valid/ready handshake is used.

Top module: `uptimer_pwm`

Register word addresses: 0 control, 1 counter, 2 load, 3 restart, 4 compare, 5 status, 6 interrupt enable, 7 wake enable, 8 system (bit1 = soft reset). Any other address reads zero.

Control bits:

| Bits | Field |
|------|-------|
| 0 | start |
| 1 | auto-reload |
| 4:2 | prescale exponent n |
| 5 | prescale enable |
| 6 | compare enable |
| 7 | idle pin level |
| 9:8 | capture mode, stored only |
| 11:10 | event select |
| 12 | toggle (1) / pulse (0) |
| 13 | capture-second, stored only |
| 14 | pin direction, 1 = input |

## Requirements
- R1: While start (control bit0) is set and prescaling is off, the counter rises by one on every clock; while start is clear it holds its value.
- R2: With prescale enable (control bit5) set, the counter advances once every 2^(n+1) clocks, where n is control bits 4:2, counted from the clock in which start was set.
- R3: When a tick arrives with the counter at all ones, overflow occurs. With auto-reload (bit1) set, the counter takes the load register value. With auto-reload clear, it becomes zero and start clears.
- R4: A write to address 1 sets the counter. Any write to address 3 copies the load register into the counter. Address 3 reads all ones.
- R5: A match event fires on a tick in which start and compare enable (bit6) are set and the counter equals the compare register; with compare enable clear, no match fires.
- R6: Event select (bits 11:10) value 1 passes overflow events to the pin. Value 2 passes both overflow and match events. Values 0 and 3 pass none.
- R7: With toggle (bit12) set, each passed event inverts the pin one clock after the event. With toggle clear, each passed event drives the pin to the inverse of the idle level for exactly one clock.
- R8: When start is clear, or event select passes no events, the pin takes the idle level (bit7) one clock later. The pin enable output is the inverse of bit14.
- R9: Status bits are bit0 match, bit1 overflow and bit2 capture. A bit is set only by an event whose enable bit (address 6) is set. Writing ones to address 5 clears those bits, and the interrupt output is high while any status bit is set.
- R10: The wake output pulses high for one clock after any event whose wake-enable bit (address 7, same bit order) is set, regardless of the interrupt enables.
- R11: Reset, or a write to address 8 with bit1 set, clears every register, the counter, the status and the pin to zero.
- R12: Control reads back its 15 written bits; the enables read back their low 3 bits; the load and compare registers read back in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cap_evt | input | 1 | Capture event strobe from the capture block |
| evt_pin | output | 1 | Event / PWM pin level |
| pin_oe | output | 1 | High when the pin is an output |
| irq | output | 1 | Interrupt, high while any status bit is set |
| wake | output | 1 | One-cycle wake-up pulse |

## Verification
Several rules are checked by assertions on every cycle. A stopped counter stays still. An overflow either reloads or stops at zero. The pin rests at its idle level whenever no events pass. A status bit never rises without its enable, and a full clear drops the interrupt line. Other behaviours need the bench's scenarios: the exact tick spacing for a given prescale exponent, the cycle in which a match inverts the pin, the one-clock width of a pulse, and the wake pulse that occurs with interrupts disabled. Register read-back masks and soft reset are also shown there.

// File: rtl/uptimer_pkg.sv
package uptimer_pkg;
  localparam int ADDR_W = 4;
  localparam int EV_W   = 3;
  localparam int CTRL_W = 15;

  localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
  localparam logic [ADDR_W-1:0] A_COUNT   = 4'd1;
  localparam logic [ADDR_W-1:0] A_LOAD    = 4'd2;
  localparam logic [ADDR_W-1:0] A_RESTART = 4'd3;
  localparam logic [ADDR_W-1:0] A_CMP     = 4'd4;
  localparam logic [ADDR_W-1:0] A_STAT    = 4'd5;
  localparam logic [ADDR_W-1:0] A_IEN     = 4'd6;
  localparam logic [ADDR_W-1:0] A_WEN     = 4'd7;
  localparam logic [ADDR_W-1:0] A_SYS     = 4'd8;

  localparam logic [1:0] SEL_NONE = 2'd0;
  localparam logic [1:0] SEL_OVF  = 2'd1;
  localparam logic [1:0] SEL_BOTH = 2'd2;

  // field order matches control bit positions, MSB first
  typedef struct packed {
    logic       dir_in;
    logic       cap_second;
    logic       toggle;
    logic [1:0] evt_sel;
    logic [1:0] cap_mode;
    logic       idle_lvl;
    logic       cmp_en;
    logic       pre_en;
    logic [2:0] pre_exp;
    logic       autold;
    logic       start;
  } ctrl_t;
endpackage

// File: rtl/uptimer_prescale.sv
module uptimer_prescale #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             pre_en,
  input  logic [EXP_W-1:0] pre_exp,
  output logic             tick
);
  localparam int PC_W = 2 ** EXP_W;

  logic [PC_W-1:0] pcnt;
  logic [PC_W-1:0] mask;

  // low (pre_exp+1) bits set: tick when they are all ones in pcnt
  always_comb begin
    for (int i = 0; i < PC_W; i++) mask[i] = (i <= int'(pre_exp));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           pcnt <= '0;
    else if (clr || !run) pcnt <= '0;
    else                  pcnt <= pcnt + 1'b1;
  end

  assign tick = run && (!pre_en || ((pcnt & mask) == mask));
endmodule

// File: rtl/uptimer_core.sv
module uptimer_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  input  logic             autold,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             wr_cnt,
  input  logic             wr_restart,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt,
  output logic             match_evt,
  output logic             stop_req
);
  logic bus_owns;
  logic at_top;

  assign bus_owns  = clr || wr_cnt || wr_restart;
  assign at_top    = &cnt;
  assign ovf_evt   = run && tick && at_top && !bus_owns;
  assign match_evt = run && tick && cmp_en && (cnt == cmp_val) && !bus_owns;
  assign stop_req  = ovf_evt && !autold;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (wr_cnt)     cnt <= wdata;
    else if (wr_restart) cnt <= load_val;
    else if (run && tick) begin
      if (at_top) cnt <= autold ? load_val : '0;
      else        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uptimer_pin.sv
module uptimer_pin (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic [1:0] evt_sel,
  input  logic       toggle,
  input  logic       idle_lvl,
  input  logic       ovf_evt,
  input  logic       match_evt,
  output logic       pin
);
  import uptimer_pkg::*;

  logic active;
  logic fire;

  assign active = (evt_sel == SEL_OVF) || (evt_sel == SEL_BOTH);
  assign fire   = (active && ovf_evt) || ((evt_sel == SEL_BOTH) && match_evt);

  always_ff @(posedge clk) begin
    if (!rst_n)                pin <= 1'b0;
    else if (clr)              pin <= 1'b0;
    else if (!run || !active)  pin <= idle_lvl;
    else if (toggle)           pin <= fire ? ~pin : pin;
    else                       pin <= fire ? ~idle_lvl : idle_lvl;
  end
endmodule

// File: rtl/uptimer_irq.sv
module uptimer_irq #(
  parameter int EV_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [EV_W-1:0] events,
  input  logic [EV_W-1:0] irq_en,
  input  logic [EV_W-1:0] wake_en,
  input  logic            w1c,
  input  logic [EV_W-1:0] w1c_bits,
  output logic [EV_W-1:0] stat,
  output logic            irq,
  output logic            wake
);
  logic [EV_W-1:0] clr_mask;

  assign clr_mask = w1c ? w1c_bits : '0;

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      stat <= '0;
      wake <= 1'b0;
    end else begin
      stat <= (stat & ~clr_mask) | (events & irq_en);
      wake <= |(events & wake_en);
    end
  end

  assign irq = |stat;
endmodule

// File: rtl/uptimer_pwm.sv
module uptimer_pwm #(
  parameter int CNT_W = 32,
  parameter int EXP_W = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic [uptimer_pkg::ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]               bus_wdata,
  output logic [CNT_W-1:0]               bus_rdata,
  input  logic                           cap_evt,
  output logic                           evt_pin,
  output logic                           pin_oe,
  output logic                           irq,
  output logic                           wake
);
  import uptimer_pkg::*;

  localparam int CTRL_PAD = CNT_W - CTRL_W;
  localparam int EV_PAD   = CNT_W - EV_W;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] load_q, cmp_q, cnt;
  logic [EV_W-1:0]  ien_q, wen_q, stat;
  logic             tick, ovf_evt, match_evt, stop_req, soft_clr;
  logic             wr_ctrl, wr_cnt, wr_load, wr_restart, wr_cmp, wr_stat, wr_ien, wr_wen;

  assign wr_ctrl    = bus_wr && (bus_addr == A_CTRL);
  assign wr_cnt     = bus_wr && (bus_addr == A_COUNT);
  assign wr_load    = bus_wr && (bus_addr == A_LOAD);
  assign wr_restart = bus_wr && (bus_addr == A_RESTART);
  assign wr_cmp     = bus_wr && (bus_addr == A_CMP);
  assign wr_stat    = bus_wr && (bus_addr == A_STAT);
  assign wr_ien     = bus_wr && (bus_addr == A_IEN);
  assign wr_wen     = bus_wr && (bus_addr == A_WEN);
  assign soft_clr   = bus_wr && (bus_addr == A_SYS) && bus_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n || soft_clr) begin
      ctrl_q <= '0;
      load_q <= '0;
      cmp_q  <= '0;
      ien_q  <= '0;
      wen_q  <= '0;
    end else begin
      if (wr_ctrl)       ctrl_q       <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      else if (stop_req) ctrl_q.start <= 1'b0;
      if (wr_load) load_q <= bus_wdata;
      if (wr_cmp)  cmp_q  <= bus_wdata;
      if (wr_ien)  ien_q  <= bus_wdata[EV_W-1:0];
      if (wr_wen)  wen_q  <= bus_wdata[EV_W-1:0];
    end
  end

  uptimer_prescale #(.EXP_W(EXP_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .run(ctrl_q.start),
    .pre_en(ctrl_q.pre_en), .pre_exp(ctrl_q.pre_exp), .tick(tick)
  );

  uptimer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .run(ctrl_q.start), .tick(tick),
    .autold(ctrl_q.autold), .cmp_en(ctrl_q.cmp_en), .load_val(load_q),
    .cmp_val(cmp_q), .wr_cnt(wr_cnt), .wr_restart(wr_restart),
    .wdata(bus_wdata), .cnt(cnt), .ovf_evt(ovf_evt), .match_evt(match_evt),
    .stop_req(stop_req)
  );

  uptimer_pin u_pin (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr), .run(ctrl_q.start),
    .evt_sel(ctrl_q.evt_sel), .toggle(ctrl_q.toggle), .idle_lvl(ctrl_q.idle_lvl),
    .ovf_evt(ovf_evt), .match_evt(match_evt), .pin(evt_pin)
  );

  uptimer_irq #(.EV_W(EV_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .clr(soft_clr),
    .events({cap_evt, ovf_evt, match_evt}), .irq_en(ien_q), .wake_en(wen_q),
    .w1c(wr_stat), .w1c_bits(bus_wdata[EV_W-1:0]), .stat(stat), .irq(irq),
    .wake(wake)
  );

  assign pin_oe = !ctrl_q.dir_in;

  always_comb begin
    case (bus_addr)
      A_CTRL:    bus_rdata = {{CTRL_PAD{1'b0}}, ctrl_q};
      A_COUNT:   bus_rdata = cnt;
      A_LOAD:    bus_rdata = load_q;
      A_RESTART: bus_rdata = '1;
      A_CMP:     bus_rdata = cmp_q;
      A_STAT:    bus_rdata = {{EV_PAD{1'b0}}, stat};
      A_IEN:     bus_rdata = {{EV_PAD{1'b0}}, ien_q};
      A_WEN:     bus_rdata = {{EV_PAD{1'b0}}, wen_q};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uptimer_pwm_chk.sv
module uptimer_pwm_chk #(
  parameter int CNT_W = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_wr,
  input logic [uptimer_pkg::ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]               bus_wdata,
  input uptimer_pkg::ctrl_t             ctrl_q,
  input logic [CNT_W-1:0]               cnt,
  input logic [CNT_W-1:0]               load_q,
  input logic [CNT_W-1:0]               cmp_q,
  input logic                           tick,
  input logic                           ovf_evt,
  input logic                           match_evt,
  input logic                           cap_evt,
  input logic [uptimer_pkg::EV_W-1:0]   stat,
  input logic [uptimer_pkg::EV_W-1:0]   ien_q,
  input logic                           irq,
  input logic                           evt_pin
);
  import uptimer_pkg::*;

  assert_hold_when_stopped_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.start && !bus_wr) |=> $stable(cnt));

  assert_reload_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.start && ctrl_q.autold && tick && (&cnt) && !bus_wr) |=> (cnt == $past(load_q)));

  assert_stop_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.start && !ctrl_q.autold && tick && (&cnt) && !bus_wr) |=> (cnt == '0 && !ctrl_q.start));

  assert_match_sets_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.start && ctrl_q.cmp_en && tick && (cnt == cmp_q) && !bus_wr && ien_q[0]) |=> stat[0]);

  assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && (!ctrl_q.start || !(ctrl_q.evt_sel == SEL_OVF || ctrl_q.evt_sel == SEL_BOTH)))
    |=> (evt_pin == $past(ctrl_q.idle_lvl)));

  assert_masked_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & ~$past(stat) & ~$past(ien_q)) == '0);

  assert_clear_drops_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT && (&bus_wdata[EV_W-1:0]) && !ovf_evt && !match_evt && !cap_evt)
    |=> !irq);
endmodule

bind uptimer_pwm uptimer_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .cnt(cnt), .load_q(load_q),
  .cmp_q(cmp_q), .tick(tick), .ovf_evt(ovf_evt), .match_evt(match_evt),
  .cap_evt(cap_evt), .stat(stat), .ien_q(ien_q), .irq(irq), .evt_pin(evt_pin)
);

// File: tb/uptimer_pwm_test.sv
`timescale 1ns/1ps
module uptimer_pwm_test;
  localparam logic [3:0] AD_CTRL = 4'd0, AD_CNT = 4'd1, AD_LOAD = 4'd2, AD_RST = 4'd3,
                         AD_CMP = 4'd4, AD_STAT = 4'd5, AD_IEN = 4'd6, AD_WEN = 4'd7,
                         AD_SYS = 4'd8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cap_evt = 1'b0;
  logic        evt_pin, pin_oe, irq, wake;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  uptimer_pwm uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_evt(cap_evt),
    .evt_pin(evt_pin), .pin_oe(pin_oe), .irq(irq), .wake(wake)
  );

  // {write, addr, data, expected read}
  localparam int NV = 20;
  localparam logic [68:0] VECS [NV] = '{
    {1'b1, AD_LOAD, 32'ha5a5a5a5, 32'h0},
    {1'b0, AD_LOAD, 32'h0,        32'ha5a5a5a5},
    {1'b1, AD_CMP,  32'h12345678, 32'h0},
    {1'b0, AD_CMP,  32'h0,        32'h12345678},
    {1'b1, AD_IEN,  32'hffffffff, 32'h0},
    {1'b0, AD_IEN,  32'h0,        32'h00000007},
    {1'b1, AD_WEN,  32'h0000000d, 32'h0},
    {1'b0, AD_WEN,  32'h0,        32'h00000005},
    {1'b1, AD_CTRL, 32'hffff7ffe, 32'h0},
    {1'b0, AD_CTRL, 32'h0,        32'h00007ffe},
    {1'b0, AD_RST,  32'h0,        32'hffffffff},
    {1'b1, AD_RST,  32'h0,        32'h0},
    {1'b0, AD_CNT,  32'h0,        32'ha5a5a5a5},
    {1'b0, 4'hf,    32'h0,        32'h0},
    {1'b1, AD_CNT,  32'h00000003, 32'h0},
    {1'b0, AD_CNT,  32'h0,        32'h00000003},
    {1'b1, AD_CTRL, 32'h0,        32'h0},
    {1'b1, AD_IEN,  32'h0,        32'h0},
    {1'b1, AD_WEN,  32'h0,        32'h0},
    {1'b0, AD_STAT, 32'h0,        32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic soft_reset();
    wr(AD_SYS, 32'h2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd(AD_CTRL, v); chk("R11 ctrl after reset", v, 32'h0);
    chk("R11 pin after reset", {31'b0, evt_pin}, 32'h0);
    chk("R11 irq/wake after reset", {30'b0, irq, wake}, 32'h0);
    chk("R8 pin_oe after reset", {31'b0, pin_oe}, 32'h1);

    // R12/R4 vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i][68]) wr(VECS[i][67:64], VECS[i][63:32]);
      else begin
        rd(VECS[i][67:64], v);
        chk($sformatf("R12/R4 vector %0d", i), v, VECS[i][31:0]);
      end
    end

    // R11 soft reset clears registers
    wr(AD_LOAD, 32'h55); wr(AD_IEN, 32'h7);
    soft_reset();
    rd(AD_LOAD, v); chk("R11 load after soft reset", v, 32'h0);
    rd(AD_IEN, v);  chk("R11 ien after soft reset", v, 32'h0);
    rd(AD_CNT, v);  chk("R11 count after soft reset", v, 32'h0);

    // R1 counting every clock, holding when stopped
    wr(AD_CNT, 32'd10); wr(AD_CTRL, 32'h1);
    step(3);
    rd(AD_CNT, v); chk("R1 count after 3 clocks", v, 32'd13);
    wr(AD_CTRL, 32'h0);
    rd(AD_CNT, v); step(4); rd(AD_CNT, v2);
    chk("R1 hold while stopped", v2, v);

    // R2 prescale exp 0 -> every 2 clocks
    soft_reset();
    wr(AD_CTRL, 32'h21);
    step(4);
    rd(AD_CNT, v); chk("R2 divide by 2", v, 32'd2);
    // R2 prescale exp 2 -> every 8 clocks
    soft_reset();
    wr(AD_CTRL, 32'h29);
    step(7);
    rd(AD_CNT, v); chk("R2 divide by 8, before tick", v, 32'd0);
    step(1);
    rd(AD_CNT, v); chk("R2 divide by 8, at tick", v, 32'd1);

    // R3 overflow with auto-reload, R9 status and clear
    soft_reset();
    wr(AD_LOAD, 32'h100); wr(AD_CNT, 32'hfffffffe); wr(AD_IEN, 32'h2);
    wr(AD_CTRL, 32'h3);
    step(1);
    chk("R9 irq low before overflow", {31'b0, irq}, 32'h0);
    step(1);
    rd(AD_CNT, v); chk("R3 reload value", v, 32'h100);
    rd(AD_STAT, v); chk("R9 overflow status", v, 32'h2);
    chk("R9 irq high", {31'b0, irq}, 32'h1);
    wr(AD_STAT, 32'h2);
    rd(AD_STAT, v); chk("R9 write-one clear", v, 32'h0);
    chk("R9 irq low after clear", {31'b0, irq}, 32'h0);

    // R3 overflow without reload, R9 masked, R10 wake
    soft_reset();
    wr(AD_WEN, 32'h2); wr(AD_CNT, 32'hffffffff); wr(AD_CTRL, 32'h1);
    step(1);
    rd(AD_CNT, v);  chk("R3 stop at zero", v, 32'h0);
    rd(AD_CTRL, v); chk("R3 start cleared", v, 32'h0);
    chk("R10 wake pulse", {31'b0, wake}, 32'h1);
    rd(AD_STAT, v); chk("R9 masked overflow not recorded", v, 32'h0);
    step(1);
    chk("R10 wake one clock", {31'b0, wake}, 32'h0);
    step(2);
    rd(AD_CNT, v);  chk("R3 holds zero", v, 32'h0);

    // R4 restart copies load
    soft_reset();
    wr(AD_LOAD, 32'h77); wr(AD_RST, 32'h12345);
    rd(AD_CNT, v); chk("R4 restart loads counter", v, 32'h77);

    // R5/R6/R7 match toggles pin
    soft_reset();
    wr(AD_IEN, 32'h1); wr(AD_CMP, 32'd5); wr(AD_CTRL, 32'h1841);
    step(5);
    chk("R7 pin before match", {31'b0, evt_pin}, 32'h0);
    step(1);
    chk("R7 toggle on match", {31'b0, evt_pin}, 32'h1);
    rd(AD_STAT, v); chk("R5 match status", v, 32'h1);

    // R5 compare disabled: no match
    soft_reset();
    wr(AD_IEN, 32'h1); wr(AD_CMP, 32'd3); wr(AD_CTRL, 32'h1801);
    step(6);
    rd(AD_STAT, v); chk("R5 no match when compare off", v, 32'h0);
    chk("R5 pin untouched", {31'b0, evt_pin}, 32'h0);

    // R6 select overflow only: match sets status but not pin
    soft_reset();
    wr(AD_IEN, 32'h1); wr(AD_CMP, 32'd3); wr(AD_CTRL, 32'h1441);
    step(6);
    rd(AD_STAT, v); chk("R6 match status with overflow-only select", v, 32'h1);
    chk("R6 pin ignores match", {31'b0, evt_pin}, 32'h0);

    // R7 pulse on overflow
    soft_reset();
    wr(AD_CNT, 32'hfffffffe); wr(AD_CTRL, 32'h403);
    step(1);
    chk("R7 pulse not yet", {31'b0, evt_pin}, 32'h0);
    step(1);
    chk("R7 pulse high", {31'b0, evt_pin}, 32'h1);
    step(1);
    chk("R7 pulse one clock", {31'b0, evt_pin}, 32'h0);

    // R8 idle level and direction
    soft_reset();
    wr(AD_CTRL, 32'h80);
    step(1);
    chk("R8 idle level", {31'b0, evt_pin}, 32'h1);
    wr(AD_CTRL, 32'h4080);
    chk("R8 pin as input", {31'b0, pin_oe}, 32'h0);

    // R9 capture status
    soft_reset();
    wr(AD_IEN, 32'h4);
    @(negedge clk); cap_evt = 1'b1;
    @(negedge clk); cap_evt = 1'b0;
    rd(AD_STAT, v); chk("R9 capture status", v, 32'h4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule